// File: doc/BRIEF.md
# Command Slot Launch and Status Tracker

This block is one command slot as software sees it through a register port. Software writes a 32-bit command word. When bit 0 of that word (the start bit) is set, the slot decodes the launch fields, hands them to an execution engine and marks itself busy. The slot then waits for the engine to report completion. It keeps a 2-bit status and a 4-bit substatus, and it holds an 18-bit exception-cause vector that the engine returns. It classifies a non-zero cause as retryable or fatal. If the launch mode asked for it, the slot raises an interrupt when the command finishes.

The control path is a four-state machine whose state code is also the visible status:

| State | Code |
|---|---|
| `ST_IDLE` | 0 |
| `ST_EXCEPT` | 1 |
| `ST_ACTIVE` | 2 |
| `ST_OSWAIT` | 3 |

The transitions are:

- **launch**: any state other than `ST_ACTIVE` goes to `ST_ACTIVE` on a start write with a legal opcode.
- **reject**: any state other than `ST_ACTIVE` goes to `ST_EXCEPT` on a start write whose opcode is above 0x0F.
- **clean finish**: `ST_ACTIVE` goes to `ST_IDLE` on done with a zero cause.
- **faulted finish**: `ST_ACTIVE` goes to `ST_EXCEPT` on done with a non-zero cause.
- **assist finish**: `ST_ACTIVE` goes to `ST_OSWAIT` on done with the assist flag set.

Every other input leaves the state unchanged.

Top module: `cmd_slot_tracker`

## Requirements
- R1: After reset, the status word reads 0, the command readback reads 0, `exe_req` is low and `irq` is low.
- R2: The status word, read with `rd_sel`=1, has this layout:
  - bits 1:0 hold the status: 0 idle, 1 exception, 2 active, 3 waiting for OS assistance.
  - bits 5:2 hold the substatus.
  - bit 6 is the retryable flag.
  - bit 7 is the fatal flag.
  - bits 25:8 hold the cause vector.
  - bits 31:26 read 0.
- R3: A write with bit 0 set, accepted outside the active state, with an opcode of 0x0F or below, makes the status 2 on the next cycle and raises `exe_req`. The engine outputs then carry the stored word's fields:
  - opcode from bits 23:16;
  - extended opcode from bits 31:24;
  - transfer type from bits 10:8;
  - first attribute from bits 12:11;
  - second attribute from bits 14:13.
- R4: A write with bit 0 clear, outside the active state, is stored and reads back with `rd_sel`=0. It leaves the status unchanged.
- R5: On completion, `exe_substatus` is captured into the substatus. Its low three bits are a message-queue result code (0 to 5). Bit 3 flags an implicit abort. A launch clears the substatus.
- R6: Completion with a zero cause returns the status to 0. A non-zero cause sets the status to 1, and the cause is held unchanged until the next launch clears it.
- R7: The retryable flag is set when the cause is non-zero and every set bit is among bits 8, 9, 10 and 16. The fatal flag is set when any cause bit outside that set is 1.
- R8: A start write whose opcode is above 0x0F sets the status to 1 with only cause bit 1 set. It raises neither `exe_req` nor `irq`.
- R9: `irq` is a one-cycle pulse in the cycle after the command leaves the active state, and only when bit 3 of the launched word (mode bit 2) was set.
- R10: Any write that arrives while the status is 2 is ignored. The command readback and the engine fields keep their values.
- R11: Completion with `exe_os_assist` high sets the status to 3. A new launch is accepted from status 3.
- R12: An `exe_done` pulse while the status is not 2 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word |
| rd_sel | input | 1 | 0 selects the command readback, 1 selects the status word |
| rd_data | output | 32 | Read data, combinational from state |
| exe_req | output | 1 | High while a command is running |
| exe_opcode | output | 8 | Opcode of the running command |
| exe_exopc | output | 8 | Extended opcode |
| exe_xtype | output | 3 | Transfer type |
| exe_attr0 | output | 2 | First access attribute |
| exe_attr1 | output | 2 | Second access attribute |
| exe_done | input | 1 | Completion pulse from the engine |
| exe_os_assist | input | 1 | Completion needs OS assistance |
| exe_cause | input | 18 | Exception-cause vector, sampled with done |
| exe_substatus | input | 4 | Substatus, sampled with done |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The assertions take for granted that the engine drives `exe_done` as a pulse lasting one cycle and that `exe_cause` and `exe_substatus` are valid in that same cycle. The interrupt and status properties hold only under that assumption. The stimulus never holds done high for two cycles in a row. Where it deliberately pulses done outside the active state to check R12, it still uses a single-cycle pulse. All writes are single-cycle strobes driven away from the clock edge.

// File: rtl/cmd_slot_pkg.sv
package cmd_slot_pkg;

    localparam int CMD_W   = 32;
    localparam int CAUSE_W = 18;
    localparam int SUB_W   = 4;

    // status code equals the state code
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXCEPT = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_OSWAIT = 2'd3
    } slot_state_e;

    // packed command word, MSB first
    typedef struct packed {
        logic [7:0] exopc;
        logic [7:0] opcode;
        logic       rsv_hi;
        logic [1:0] attr1;
        logic [1:0] attr0;
        logic [2:0] xtype;
        logic [3:0] rsv_lo;
        logic [2:0] mode;
        logic       start;
    } cmd_word_t;

endpackage

// File: rtl/cmd_word_decode.sv
module cmd_word_decode
    import cmd_slot_pkg::*;
#(
    parameter int OPC_LIMIT = 15,
    parameter int INT_BIT   = 2
) (
    input  logic [CMD_W-1:0] word_i,
    output cmd_word_t        fld_o,
    output logic             start_o,
    output logic             opc_bad_o,
    output logic             int_req_o
);

    always_comb begin
        fld_o     = cmd_word_t'(word_i);
        start_o   = fld_o.start;
        opc_bad_o = (int'(fld_o.opcode) > OPC_LIMIT);
        int_req_o = fld_o.mode[INT_BIT];
    end

endmodule

// File: rtl/cause_classify.sv
module cause_classify #(
    parameter int           W          = 18,
    parameter logic [W-1:0] RETRY_MASK = 18'h10700
) (
    input  logic [W-1:0] cause_i,
    output logic         retry_o,
    output logic         fatal_o
);

    logic [W-1:0] outside;

    // per-bit flag for causes outside the retryable set
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (RETRY_MASK[i]) begin : g_ok
            assign outside[i] = 1'b0;
        end else begin : g_bad
            assign outside[i] = cause_i[i];
        end
    end

    always_comb begin
        fatal_o = |outside;
        retry_o = (|cause_i) && !fatal_o;
    end

endmodule

// File: rtl/slot_fsm.sv
module slot_fsm
    import cmd_slot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic        start_i,
    input  logic        opc_bad_i,
    input  logic        int_req_i,
    input  logic        done_i,
    input  logic        os_i,
    input  logic        cause_nz_i,
    output slot_state_e state_o,
    output logic        wr_take_o,
    output logic        launch_o,
    output logic        reject_o,
    output logic        finish_o,
    output logic        irq_o
);

    slot_state_e state_q, state_d;
    logic        int_q;
    logic        irq_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            int_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (launch_o) int_q <= int_req_i;
            irq_q <= finish_o && int_q;
        end
    end

    // next state and strobes
    always_comb begin
        wr_take_o = wr_en_i && (state_q != ST_ACTIVE);
        launch_o  = wr_take_o && start_i && !opc_bad_i;
        reject_o  = wr_take_o && start_i && opc_bad_i;
        finish_o  = (state_q == ST_ACTIVE) && done_i;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE, ST_EXCEPT, ST_OSWAIT: begin
                if (launch_o)      state_d = ST_ACTIVE;
                else if (reject_o) state_d = ST_EXCEPT;
            end
            ST_ACTIVE: begin
                if (done_i) begin
                    if (os_i)            state_d = ST_OSWAIT;
                    else if (cause_nz_i) state_d = ST_EXCEPT;
                    else                 state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;
    assign irq_o   = irq_q;

    // a pulse never lasts two cycles (R9)
    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // interrupt only follows an active cycle (R9)
    p_irq_after_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(state_q == ST_ACTIVE));

    // entering active needs a start write (R3)
    p_active_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_ACTIVE) |-> $past(wr_en_i && start_i && !opc_bad_i));

    // engine completion with assist lands in OS wait (R11)
    p_assist_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && done_i && os_i) |=> state_q == ST_OSWAIT);

endmodule

// File: rtl/cmd_slot_tracker.sv
module cmd_slot_tracker
    import cmd_slot_pkg::*;
#(
    parameter int                 OPC_LIMIT   = 15,
    parameter int                 INT_BIT     = 2,
    parameter int                 INVALID_BIT = 1,
    parameter logic [CAUSE_W-1:0] RETRY_MASK  = 18'h10700
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CMD_W-1:0]   wr_data,
    input  logic               rd_sel,
    output logic [CMD_W-1:0]   rd_data,
    output logic               exe_req,
    output logic [7:0]         exe_opcode,
    output logic [7:0]         exe_exopc,
    output logic [2:0]         exe_xtype,
    output logic [1:0]         exe_attr0,
    output logic [1:0]         exe_attr1,
    input  logic               exe_done,
    input  logic               exe_os_assist,
    input  logic [CAUSE_W-1:0] exe_cause,
    input  logic [SUB_W-1:0]   exe_substatus,
    output logic               irq
);

    localparam int PAD_W = CMD_W - CAUSE_W - SUB_W - 4;
    localparam logic [CAUSE_W-1:0] INVALID_VEC = CAUSE_W'(1) << INVALID_BIT;

    cmd_word_t    wr_fld;
    logic         wr_start, wr_bad, wr_int;
    slot_state_e  state;
    logic         wr_take, launch, reject, finish;
    logic         retry, fatal;

    cmd_word_t          cmd_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [SUB_W-1:0]   sub_q;

    cmd_word_decode #(.OPC_LIMIT(OPC_LIMIT), .INT_BIT(INT_BIT)) u_dec (
        .word_i    (wr_data),
        .fld_o     (wr_fld),
        .start_o   (wr_start),
        .opc_bad_o (wr_bad),
        .int_req_o (wr_int)
    );

    slot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .start_i    (wr_start),
        .opc_bad_i  (wr_bad),
        .int_req_i  (wr_int),
        .done_i     (exe_done),
        .os_i       (exe_os_assist),
        .cause_nz_i (|exe_cause),
        .state_o    (state),
        .wr_take_o  (wr_take),
        .launch_o   (launch),
        .reject_o   (reject),
        .finish_o   (finish),
        .irq_o      (irq)
    );

    cause_classify #(.W(CAUSE_W), .RETRY_MASK(RETRY_MASK)) u_cls (
        .cause_i (cause_q),
        .retry_o (retry),
        .fatal_o (fatal)
    );

    // slot registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            cause_q <= '0;
            sub_q   <= '0;
        end else begin
            if (wr_take) cmd_q <= wr_fld;
            if (launch) begin
                cause_q <= '0;
                sub_q   <= '0;
            end else if (reject) begin
                cause_q <= INVALID_VEC;
                sub_q   <= '0;
            end else if (finish) begin
                cause_q <= exe_cause;
                sub_q   <= exe_substatus;
            end
        end
    end

    // engine side and read mux
    always_comb begin
        exe_req    = (state == ST_ACTIVE);
        exe_opcode = cmd_q.opcode;
        exe_exopc  = cmd_q.exopc;
        exe_xtype  = cmd_q.xtype;
        exe_attr0  = cmd_q.attr0;
        exe_attr1  = cmd_q.attr1;
        if (rd_sel) rd_data = {{PAD_W{1'b0}}, cause_q, fatal, retry, sub_q, state};
        else        rd_data = cmd_q;
    end

    // a fresh launch starts with an empty cause (R6)
    p_cause_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exe_req) |-> cause_q == '0);

    // idle never carries a cause (R6)
    p_idle_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> cause_q == '0);

    // bad opcode records only the invalid cause and does not start (R8)
    p_bad_opcode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !exe_req && wr_data[0] && wr_bad) |=> (cause_q == INVALID_VEC && !exe_req));

    // writes during a running command leave it alone (R10)
    p_busy_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && exe_req) |=> $stable(cmd_q));

    // substatus is frozen outside completion and launch (R5)
    p_sub_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !exe_done) |=> $stable(sub_q));

endmodule

// File: tb/cmd_slot_tracker_tb.sv
module cmd_slot_tracker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b1;
    logic [31:0] rd_data;
    logic        exe_req;
    logic [7:0]  exe_opcode, exe_exopc;
    logic [2:0]  exe_xtype;
    logic [1:0]  exe_attr0, exe_attr1;
    logic        exe_done = 1'b0;
    logic        exe_os_assist = 1'b0;
    logic [17:0] exe_cause = '0;
    logic [3:0]  exe_substatus = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cmd_slot_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .exe_req(exe_req),
        .exe_opcode(exe_opcode), .exe_exopc(exe_exopc), .exe_xtype(exe_xtype),
        .exe_attr0(exe_attr0), .exe_attr1(exe_attr1), .exe_done(exe_done),
        .exe_os_assist(exe_os_assist), .exe_cause(exe_cause),
        .exe_substatus(exe_substatus), .irq(irq)
    );

    // reference model state
    int          m_st = 0;
    int          m_sub = 0;
    logic [17:0] m_cause = '0;
    logic [31:0] m_cmd = '0;
    bit          m_int = 0;
    bit          m_irq = 0;

    function automatic logic [31:0] exp_status();
        logic [17:0] retry_set;
        logic        fat, ret;
        retry_set = 18'h0;
        retry_set[8] = 1'b1; retry_set[9] = 1'b1; retry_set[10] = 1'b1; retry_set[16] = 1'b1;
        fat = (m_cause & ~retry_set) != 0;
        ret = (m_cause != 0) && !fat;
        return {6'd0, m_cause, fat, ret, 4'(m_sub), 2'(m_st)};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_sub = 0; m_cause = '0; m_cmd = '0; m_int = 0; m_irq = 0;
        end else begin
            m_irq = 0;
            if (m_st == 2) begin
                if (exe_done) begin
                    m_irq = m_int;
                    m_sub = int'(exe_substatus);
                    m_cause = exe_cause;
                    m_st = exe_os_assist ? 3 : (exe_cause != 0 ? 1 : 0);
                end
            end else if (wr_en) begin
                m_cmd = wr_data;
                if (wr_data[0]) begin
                    if (wr_data[23:16] > 8'h0F) begin
                        m_st = 1; m_cause = 18'h2; m_sub = 0;
                    end else begin
                        m_st = 2; m_cause = '0; m_sub = 0; m_int = wr_data[3];
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rd_sel) chk("R2 status word", rd_data, exp_status());
            else        chk("R4 command readback", rd_data, m_cmd);
            chk("R9 irq", {31'd0, irq}, {31'd0, m_irq});
            chk("R3 exe_req", {31'd0, exe_req}, {31'd0, m_st == 2});
            if (m_st == 2) begin
                chk("R3 opcode", {24'd0, exe_opcode}, {24'd0, m_cmd[23:16]});
                chk("R3 fields", {19'd0, exe_exopc, exe_xtype, exe_attr0},
                    {19'd0, m_cmd[31:24], m_cmd[10:8], m_cmd[12:11]});
                chk("R3 attr1", {30'd0, exe_attr1}, {30'd0, m_cmd[14:13]});
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic put(input logic [31:0] w);
        wr_en = 1'b1; wr_data = w;
        cyc();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic done(input logic [17:0] c, input logic [3:0] s, input logic os);
        exe_done = 1'b1; exe_cause = c; exe_substatus = s; exe_os_assist = os;
        cyc();
        exe_done = 1'b0; exe_cause = '0; exe_substatus = '0; exe_os_assist = 1'b0;
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 status", rd_data, 32'h0);
        chk("R1 irq/req", {30'd0, irq, exe_req}, 32'h0);
        rd_sel = 1'b0; #1;
        chk("R1 command", rd_data, 32'h0);

        // R4 plain write stores without launching
        put(32'h0503_0000);
        chk("R4 readback", rd_data, 32'h0503_0000);
        rd_sel = 1'b1; #1;
        chk("R4 status idle", rd_data, 32'h0);

        // R3 launch decode
        put(32'h1102_4B01);
        chk("R2 active code", rd_data, 32'h2);
        chk("R3 req", {31'd0, exe_req}, 32'h1);
        chk("R3 opcode", {24'd0, exe_opcode}, 32'h02);
        chk("R3 exopc", {24'd0, exe_exopc}, 32'h11);
        chk("R3 xtype", {29'd0, exe_xtype}, 32'h3);
        chk("R3 attrs", {28'd0, exe_attr1, exe_attr0}, 32'h9);

        // R10 write while active ignored
        put(32'h0005_0001);
        rd_sel = 1'b0; #1;
        chk("R10 readback", rd_data, 32'h1102_4B01);
        chk("R10 opcode", {24'd0, exe_opcode}, 32'h02);
        rd_sel = 1'b1; #1;
        done(18'h0, 4'h0, 1'b0);
        chk("R6 clean finish", rd_data, 32'h0);
        chk("R9 no irq", {31'd0, irq}, 32'h0);

        // R9 interrupt mode, R5 substatus with abort flag
        put(32'h0001_0009);
        done(18'h0, 4'h9, 1'b0);
        chk("R5 substatus", rd_data, 32'h24);
        chk("R9 irq pulse", {31'd0, irq}, 32'h1);
        cyc();
        chk("R9 irq single", {31'd0, irq}, 32'h0);

        // R7 retryable cause, R6 hold
        put(32'h000C_0001);
        done(18'h10200, 4'h2, 1'b0);
        chk("R7 retryable", rd_data, 32'h0102_0049);
        repeat (3) cyc();
        chk("R6 cause held", rd_data, 32'h0102_0049);
        put(32'h000D_0001);
        chk("R6 launch clears", rd_data, 32'h2);
        done(18'h00208, 4'h0, 1'b0);
        chk("R7 fatal", rd_data, 32'h0002_0881);

        // R8 invalid opcode, with interrupt mode
        put(32'h0010_0009);
        chk("R8 invalid", rd_data, 32'h0000_0281);
        chk("R8 no req", {31'd0, exe_req}, 32'h0);
        cyc();
        chk("R8 no irq", {31'd0, irq}, 32'h0);

        // R11 assist state and relaunch from it
        put(32'h0008_0001);
        done(18'h0, 4'h0, 1'b1);
        chk("R11 assist", rd_data, 32'h3);
        put(32'h0009_0001);
        chk("R11 relaunch", rd_data, 32'h2);
        done(18'h0, 4'h0, 1'b0);

        // R12 stray done
        done(18'h3FFFF, 4'hF, 1'b0);
        chk("R12 ignored", rd_data, 32'h0);

        // R5 queue result codes
        for (int k = 0; k < 6; k++) begin
            put(32'h0002_0001);
            done(18'h0, 4'(k), 1'b0);
            chk("R5 code", rd_data, 32'(k << 2));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule